// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block times programmed-I/O accesses on one parallel ATA channel with two attached drives. All timing is counted in bus clocks. A host request carries the target drive, the direction and a flag that marks an access to the data port. The block lowers the active-low read strobe or the active-low write strobe. At a programmed sample point it looks at the device ready line. If that line is low and sampling is on, the block holds the strobe until the line goes high. It then releases the strobe and pulses a completion flag. After that it enforces a recovery gap before it will accept the next request.

Two 8-bit configuration registers are written through a small write port, and both reset to 00h. The channel register holds, for each drive, a ready-sampling enable and a fast-timing select. It also holds a sample-point code and a recovery code that both drives share. The drive-1 register holds a private sample-point code and a private recovery code for drive 1, plus a bit that switches drive 1 over to those private codes. Without a fast-timing select, and for any access that is not to the data port, the block falls back to slow compatible timing: a 5-clock sample point and a 4-clock recovery. The timing for an access is captured when its request is accepted.

Top module: `pata_pio_strobe`

## Requirements
- R1: After reset both registers read as 00h in effect: both strobes are high, `done` is low and `req_ready` is high. An access then uses a 5-clock strobe and a 4-clock recovery, with the ready line ignored.
- R2: A read access (`req_write`=0) drives `dior_n` low and leaves `diow_n` high. A write access does the reverse. The two strobes are never low together.
- R3: When programmed timing applies, the sample-point code gives the strobe width in clocks when the ready line is high at the sample point: 00→5, 01→4, 10→3, and the reserved 11→5. The shared code is in channel bits [5:4] and the drive-1 code is in drive-1 bits [1:0].
- R4: The recovery code gives the clocks from the last ready sample to the earliest next strobe: 00→4, 01→3, 10→2, 11→1. `req_ready` rises exactly when that gap has elapsed. The shared code is in channel bits [7:6] and the drive-1 code is in drive-1 bits [3:2].
- R5: When the drive's sampling enable is 1 (channel bit 0 for drive 0, bit 2 for drive 1), a low ready line at the sample point holds the strobe. The line is sampled again every clock, and the strobe is released one clock after the first clock edge at which it is high.
- R6: When the drive's sampling enable is 0, the ready line has no effect and the strobe width is the sample-point value alone.
- R7: When the drive's fast-timing bit is 0 (channel bit 1 for drive 0, bit 3 for drive 1), data-port accesses use the compatible 5/4 timing.
- R8: An access with `req_dataport`=0 uses the compatible 5/4 timing whatever the fast-timing bit says.
- R9: A drive-1 access with programmed timing uses the drive-1 register codes when drive-1 bit 4 is 1, and the shared channel codes when that bit is 0.
- R10: `done` is high for exactly one clock, the first clock in which the strobe is back high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the channel register, 1 selects the drive-1 register |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Access request |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_dataport | input | 1 | 1 when the access targets the data port |
| req_ready | output | 1 | The request is accepted at the next edge when this is high |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| iordy | input | 1 | Device ready line |
| done | output | 1 | One-clock completion pulse |

## Verification
Directed accesses step through every sample-point and recovery code, including the reserved one, so each code maps to a measurable strobe width and recovery gap. Holding the ready line low for several clocks separates drives with sampling on, whose strobe grows by exactly those clocks, from drives with sampling off, whose strobe does not grow. Non-data-port accesses, cleared fast-timing bits and both settings of the drive-1 switch are run against register contents that would otherwise give a short timing, so a wrong source selection shows up as a wrong width. Random register contents, drives, directions and ready stalls then cover the combinations between these cases.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int NUM_DRIVES = 2;
    localparam int DRV_W      = $clog2(NUM_DRIVES);
    localparam int REG_W      = 8;
    localparam int CNT_W      = 3;

    localparam logic [CNT_W-1:0] COMPAT_SAMPLE = CNT_W'(5);
    localparam logic [CNT_W-1:0] COMPAT_RECOV  = CNT_W'(4);

    typedef struct packed {
        logic [1:0] sample_code;
        logic [1:0] recov_code;
    } field_pair_t;

    typedef struct packed {
        logic iordy_en;
        logic fast_en;
    } drive_ctl_t;

    typedef struct packed {
        logic [CNT_W-1:0] sample_clks;
        logic [CNT_W-1:0] recov_clks;
        logic             iordy_en;
    } cycle_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_RECOV  = 2'd2
    } pio_state_e;

    function automatic logic [CNT_W-1:0] decode_sample(input logic [1:0] code);
        case (code)
            2'b01:   return CNT_W'(4);
            2'b10:   return CNT_W'(3);
            default: return CNT_W'(5);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] decode_recov(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(4);
            2'b01:   return CNT_W'(3);
            2'b10:   return CNT_W'(2);
            default: return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_timing_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic                              cfg_sel,
    input  logic [REG_W-1:0]                  cfg_wdata,
    output drive_ctl_t [NUM_DRIVES-1:0]       ctl_o,
    output field_pair_t                       shared_o,
    output field_pair_t                       d1_o,
    output logic                              d1_sep_o
);

    logic [REG_W-1:0] chan_q;
    logic [4:0]       d1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            d1_q   <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) d1_q   <= cfg_wdata[4:0];
            else         chan_q <= cfg_wdata;
        end
    end

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        assign ctl_o[g].iordy_en = chan_q[2*g];
        assign ctl_o[g].fast_en  = chan_q[2*g+1];
    end

    assign shared_o.sample_code = chan_q[5:4];
    assign shared_o.recov_code  = chan_q[7:6];
    assign d1_o.sample_code     = d1_q[1:0];
    assign d1_o.recov_code      = d1_q[3:2];
    assign d1_sep_o             = d1_q[4];

endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_timing_pkg::*;
(
    input  drive_ctl_t [NUM_DRIVES-1:0] ctl_i,
    input  field_pair_t                 shared_i,
    input  field_pair_t                 d1_i,
    input  logic                        d1_sep_i,
    input  logic [DRV_W-1:0]            drive_i,
    input  logic                        dataport_i,
    output cycle_timing_t               timing_o
);

    drive_ctl_t  ctl;
    field_pair_t fields;

    always_comb begin
        ctl    = ctl_i[drive_i];
        fields = (drive_i == DRV_W'(1) && d1_sep_i) ? d1_i : shared_i;

        timing_o.iordy_en = ctl.iordy_en;
        if (ctl.fast_en && dataport_i) begin
            timing_o.sample_clks = decode_sample(fields.sample_code);
            timing_o.recov_clks  = decode_recov(fields.recov_code);
        end else begin
            timing_o.sample_clks = COMPAT_SAMPLE;
            timing_o.recov_clks  = COMPAT_RECOV;
        end
    end

endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
    import pio_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  cycle_timing_t timing_i,
    input  logic          iordy,
    output logic          req_ready,
    output logic          dior_n,
    output logic          diow_n,
    output logic          done
);

    pio_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] recov_q;
    logic             ien_q;
    logic             accept;

    assign req_ready = (state_q == ST_IDLE) ||
                       (state_q == ST_RECOV && cnt_q == '0);
    assign accept    = req_ready && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            recov_q <= '0;
            ien_q   <= 1'b0;
            dior_n  <= 1'b1;
            diow_n  <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state_q <= ST_STROBE;
                cnt_q   <= timing_i.sample_clks - CNT_W'(1);
                recov_q <= timing_i.recov_clks;
                ien_q   <= timing_i.iordy_en;
                dior_n  <= req_write;
                diow_n  <= !req_write;
            end else begin
                case (state_q)
                    ST_STROBE: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end else if (!ien_q || iordy) begin
                            dior_n  <= 1'b1;
                            diow_n  <= 1'b1;
                            done    <= 1'b1;
                            state_q <= ST_RECOV;
                            cnt_q   <= recov_q - CNT_W'(1);
                        end
                    end
                    ST_RECOV: begin
                        if (cnt_q != '0) cnt_q   <= cnt_q - CNT_W'(1);
                        else             state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pata_pio_strobe.sv
module pata_pio_strobe
    import pio_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    input  logic [DRV_W-1:0] req_drive,
    input  logic             req_write,
    input  logic             req_dataport,
    output logic             req_ready,
    output logic             dior_n,
    output logic             diow_n,
    input  logic             iordy,
    output logic             done
);

    drive_ctl_t [NUM_DRIVES-1:0] ctl;
    field_pair_t                 shared_f;
    field_pair_t                 d1_f;
    logic                        d1_sep;
    cycle_timing_t               timing;

    pio_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .ctl_o    (ctl),
        .shared_o (shared_f),
        .d1_o     (d1_f),
        .d1_sep_o (d1_sep)
    );

    pio_timing_sel u_sel (
        .ctl_i     (ctl),
        .shared_i  (shared_f),
        .d1_i      (d1_f),
        .d1_sep_i  (d1_sep),
        .drive_i   (req_drive),
        .dataport_i(req_dataport),
        .timing_o  (timing)
    );

    pio_strobe_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .timing_i (timing),
        .iordy    (iordy),
        .req_ready(req_ready),
        .dior_n   (dior_n),
        .diow_n   (diow_n),
        .done     (done)
    );

endmodule

// File: rtl/pata_pio_strobe_chk.sv
module pata_pio_strobe_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic dior_n,
    input logic diow_n,
    input logic done
);

    logic       active;
    logic [7:0] width_cnt;

    assign active = !dior_n || !diow_n;

    always_ff @(posedge clk) begin
        if (rst)                 width_cnt <= '0;
        else if (!active)        width_cnt <= '0;
        else if (width_cnt != '1) width_cnt <= width_cnt + 8'd1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n)); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        active |-> !req_ready); // R4

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && ($past(!dior_n) || $past(!diow_n)))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (width_cnt >= 8'd3)); // R3

endmodule

bind pata_pio_strobe pata_pio_strobe_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .dior_n   (dior_n),
    .diow_n   (diow_n),
    .done     (done)
);

// File: tb/pata_pio_strobe_tb_top.sv
module pata_pio_strobe_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       req_valid = 1'b0;
    logic [0:0] req_drive = '0;
    logic       req_write = 1'b0;
    logic       req_dataport = 1'b0;
    logic       req_ready;
    logic       dior_n;
    logic       diow_n;
    logic       iordy = 1'b1;
    logic       done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] chan_sh = '0;
    logic [7:0] d1_sh   = '0;

    always #4 clk = ~clk;

    pata_pio_strobe dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_drive(req_drive),
        .req_write(req_write), .req_dataport(req_dataport),
        .req_ready(req_ready), .dior_n(dior_n), .diow_n(diow_n),
        .iordy(iordy), .done(done)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_sample(input logic [1:0] c);
        return (c == 2'b01) ? 4 : (c == 2'b10) ? 3 : 5;
    endfunction

    function automatic int exp_recov(input logic [1:0] c);
        return 4 - int'(c);
    endfunction

    task automatic expect_timing(input int drv, input bit dport,
                                 output int s, output int r, output bit ien);
        bit fast;
        ien  = chan_sh[2*drv];
        fast = chan_sh[2*drv+1];
        s = 5; r = 4;
        if (fast && dport) begin
            if (drv == 1 && d1_sh[4]) begin
                s = exp_sample(d1_sh[1:0]); r = exp_recov(d1_sh[3:2]);
            end else begin
                s = exp_sample(chan_sh[5:4]); r = exp_recov(chan_sh[7:6]);
            end
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) d1_sh = data; else chan_sh = data;
    endtask

    task automatic access(input string tag, input int drv, input bit wr,
                          input bit dport, input int stall);
        int s, r, width, n, exp_w;
        bit ien;
        expect_timing(drv, dport, s, r, ien);
        exp_w = ien ? s + stall : s;
        @(negedge clk);
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        req_valid = 1'b1; req_drive = 1'(drv); req_write = wr;
        req_dataport = dport; iordy = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "read strobe level", int'(dior_n), int'(wr));
        check("R2", "write strobe level", int'(diow_n), int'(!wr));
        width = 0;
        while ((!dior_n || !diow_n) && width < 40) begin
            width++;
            if (width == s + stall) iordy = 1'b1;
            @(negedge clk);
        end
        iordy = 1'b1;
        check(tag, "strobe width", width, exp_w);
        check("R10", "done at release", int'(done), 1);
        n = 1;
        while (!req_ready && n < 40) begin @(negedge clk); n++; end
        check(tag, "recovery clocks", n, r);
        if (n == 1) @(negedge clk);
        check("R10", "done single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "dior_n after reset", int'(dior_n), 1);
        check("R1", "diow_n after reset", int'(diow_n), 1);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "ready after reset", int'(req_ready), 1);
        access("R1", 0, 1'b0, 1'b1, 2);

        cfg_write(1'b0, 8'h63);               // sc=10 rc=01, drive0 fast+ien
        access("R3", 0, 1'b1, 1'b1, 0);
        access("R5", 0, 1'b0, 1'b1, 3);
        access("R8", 0, 1'b1, 1'b0, 0);

        cfg_write(1'b0, 8'h62);               // drive0 fast, ien off
        access("R6", 0, 1'b0, 1'b1, 3);

        cfg_write(1'b0, 8'hF2);               // reserved sc=11, rc=11
        access("R3", 0, 1'b0, 1'b1, 0);
        access("R4", 0, 1'b1, 1'b1, 1);

        cfg_write(1'b0, 8'h1C);               // drive1 fast+ien, sc=01 rc=00
        cfg_write(1'b1, 8'h0E);               // private codes, switch off
        access("R9", 1, 1'b0, 1'b1, 0);
        cfg_write(1'b1, 8'h1E);               // switch on
        access("R9", 1, 1'b1, 1'b1, 2);

        cfg_write(1'b0, 8'hA4);               // drive1 ien only, fast off
        access("R7", 1, 1'b0, 1'b1, 1);

        for (int i = 0; i < 40; i++) begin
            if (($urandom % 10) < 3) cfg_write(1'($urandom % 2), 8'($urandom));
            access("R3", int'($urandom % 2), 1'($urandom % 2),
                   1'(($urandom % 4) != 0), int'($urandom % 4));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule